// File: doc/BRIEF.md
# Count-Triggered Recorded Prefetch Lists

This block keeps a timeline of the memory and branch activity seen while a future task runs ahead speculatively. When that task later runs for real, the block plays the timeline back as instruction-cache prefetches, data-cache prefetches and branch-predictor warm-up hints. Each hint goes out shortly before the point in the task where it is needed.

In record mode the environment offers one record per cycle. A record is an instruction-fetch address, a data-access address, or a branch, and it comes with the retired-instruction count of the task at that moment. The environment restarts that count from zero at the start of every task. Each kind of record goes to its own in-order list, and there is one set of three lists for each of the tasks that can be recorded ahead.

In replay mode the block looks at the head of each list of the task now running. A head entry is released once the live instruction count plus a fixed lead is greater than the count stored with the entry. A task-switch pulse has two meanings:
- In record mode it moves recording on to the next task's lists.
- In replay mode it throws away whatever is left of the finished task and moves replay on to the next task.

Top module: `memo_prefetch_top`

## Requirements
- R1: After reset no prefetch or hint output is valid, every overflow flag is 0, and recording and replay both start at task slot 0.
- R2: In record mode a record with `rec_valid_i`=1 is appended to the list picked by `rec_kind_i`: 0 is the instruction list, 1 the data list and 2 the branch list. Kind 3 is dropped. Nothing is released while in record mode.
- R3: In replay mode the head entry of a list in the current replay slot is released in the cycle after an edge at which `icount_i` + LEAD > stored count (LEAD defaults to 100). While `icount_i` + LEAD <= stored count it is held.
- R4: Each list is consumed in the order it was filled, and releases at most one entry per cycle. When several entries qualify at once they come out on consecutive cycles.
- R5: The three lists are released independently, so a head that is not yet due in one list never delays a due head in another.
- R6: A released branch hint carries the recorded branch address on `bp_addr_o`, the target on `bp_target_o` and the direction on `bp_taken_o`. Instruction and data prefetches carry the recorded address.
- R7: A record aimed at a list that already holds DEPTH entries (default 8) is dropped, and `ovf_o[slot]` goes to 1 for that task slot. The entries already held still replay.
- R8: A task-switch pulse in record mode advances the record slot, wrapping after NSLOT (default 2) slots. A record offered in the same cycle goes to the slot in use before the switch.
- R9: A task-switch pulse in replay mode empties all three lists of the current replay slot, clears that slot's overflow flag, releases nothing in that cycle and advances the replay slot.
- R10: Records offered in replay mode are ignored, so they change neither what is later replayed nor the overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_replay_i | input | 1 | 0 = record, 1 = replay |
| icount_i | input | CNT_W | Retired-instruction count of the current task |
| rec_valid_i | input | 1 | A record is offered this cycle |
| rec_kind_i | input | 2 | 0 instruction, 1 data, 2 branch, 3 none |
| rec_addr_i | input | ADDR_W | Fetch address, data address or branch address |
| rec_target_i | input | ADDR_W | Branch target (branch records only) |
| rec_taken_i | input | 1 | Branch direction, 1 = taken (branch records only) |
| task_switch_i | input | 1 | One-cycle task switch pulse |
| ipf_valid_o | output | 1 | Instruction prefetch request valid |
| ipf_addr_o | output | ADDR_W | Instruction prefetch address |
| dpf_valid_o | output | 1 | Data prefetch request valid |
| dpf_addr_o | output | ADDR_W | Data prefetch address |
| bp_valid_o | output | 1 | Branch-predictor update valid |
| bp_addr_o | output | ADDR_W | Branch address for the update |
| bp_target_o | output | ADDR_W | Branch target for the update |
| bp_taken_o | output | 1 | Branch direction for the update |
| ovf_o | output | NSLOT | Per-slot flag: a record was dropped because a list was full |

## Verification
The stimulus drives the instruction count in several ways, and each one separates a different fault:
- Holding the count still with one instruction entry already due and the data head not yet due separates the lists from one another.
- A jump that makes two data entries due at once shows whether the list drains one entry per cycle in stored order.
- A slow ramp checks the exact boundary where the live count plus the lead first passes the stored count.

One task is recorded with more entries than a list holds, which checks that the extra record is dropped and that the flag is raised. The replay of the other task is cut short by a switch, which shows whether its leftovers are discarded rather than replayed later. Junk records are offered throughout replay, so any leak of them into a list shows up as a wrong prefetch.

// File: rtl/memo_pf_pkg.sv
package memo_pf_pkg;

    typedef enum logic [1:0] {
        KIND_INSN   = 2'd0,
        KIND_DATA   = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_NONE   = 2'd3
    } rec_kind_e;

endpackage

// File: rtl/memo_pf_slots.sv
module memo_pf_slots #(
    parameter int NSLOT = 2,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              switch_i,
    input  logic              replay_i,
    output logic [SLOT_W-1:0] wr_slot_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic              clr_o,
    output logic [SLOT_W-1:0] clr_slot_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] wr;
        logic [SLOT_W-1:0] rd;
    } slot_st_t;

    slot_st_t q, d;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] s);
        bump = (s == SLOT_W'(NSLOT - 1)) ? '0 : s + SLOT_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (switch_i) begin
            if (replay_i) d.rd = bump(q.rd);
            else          d.wr = bump(q.wr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_slot_o  = q.wr;
    assign rd_slot_o  = q.rd;
    assign clr_o      = switch_i && replay_i;
    assign clr_slot_o = q.rd;

    AST_RECORD_SLOT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((NSLOT > 1) && switch_i && !replay_i) |=> (wr_slot_o != $past(wr_slot_o))); // R8

    AST_REPLAY_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_i && replay_i) |=> $stable(wr_slot_o)); // R9

endmodule

// File: rtl/memo_pf_list.sv
module memo_pf_list #(
    parameter int PAY_W      = 32,
    parameter int CNT_W      = 16,
    parameter int DEPTH_LOG2 = 3,
    parameter int NSLOT      = 2,
    parameter int LEAD       = 100,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int SLOT_N = 1 << SLOT_W,
    localparam int PTR_W  = DEPTH_LOG2,
    localparam int DEPTH  = 1 << DEPTH_LOG2,
    localparam int FILL_W = PTR_W + 1,
    localparam int ENT_W  = CNT_W + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [CNT_W-1:0]  push_cnt_i,
    input  logic [PAY_W-1:0]  push_pay_i,
    input  logic              replay_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [CNT_W-1:0]  live_cnt_i,
    input  logic              clr_i,
    input  logic [SLOT_W-1:0] clr_slot_i,
    output logic              out_valid_o,
    output logic [PAY_W-1:0]  out_pay_o,
    output logic [NSLOT-1:0]  ovf_o
);

    localparam logic [CNT_W:0]  LEAD_V = (CNT_W + 1)'(LEAD);
    localparam logic [FILL_W-1:0] FULL_V = FILL_W'(DEPTH);

    typedef struct packed {
        logic [SLOT_N*DEPTH-1:0][ENT_W-1:0] mem;
        logic [SLOT_N-1:0][PTR_W-1:0]       head;
        logic [SLOT_N-1:0][FILL_W-1:0]      fill;
        logic [SLOT_N-1:0]                  ovf;
        logic                               vld;
        logic [PAY_W-1:0]                   pay;
    } list_st_t;

    list_st_t q, d;

    logic [ENT_W-1:0] head_ent;
    logic [CNT_W:0]   reach;
    logic             due;
    logic [PTR_W-1:0] tail;

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        head_ent = q.mem[{rd_slot_i, q.head[rd_slot_i]}];
        reach    = {1'b0, live_cnt_i} + LEAD_V;
        due      = reach > {1'b0, head_ent[ENT_W-1 -: CNT_W]};
        tail     = q.head[wr_slot_i] + q.fill[wr_slot_i][PTR_W-1:0];

        if (clr_i) begin
            d.fill[clr_slot_i] = '0;
            d.head[clr_slot_i] = '0;
            d.ovf[clr_slot_i]  = 1'b0;
        end else if (replay_i && (q.fill[rd_slot_i] != '0) && due) begin
            d.vld             = 1'b1;
            d.pay             = head_ent[PAY_W-1:0];
            d.head[rd_slot_i] = q.head[rd_slot_i] + PTR_W'(1);
            d.fill[rd_slot_i] = q.fill[rd_slot_i] - FILL_W'(1);
        end

        if (push_i) begin
            if (q.fill[wr_slot_i] == FULL_V) begin
                d.ovf[wr_slot_i] = 1'b1;
            end else begin
                d.mem[{wr_slot_i, tail}] = {push_cnt_i, push_pay_i};
                d.fill[wr_slot_i]        = q.fill[wr_slot_i] + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid_o = q.vld;
    assign out_pay_o   = q.pay;
    assign ovf_o       = q.ovf[NSLOT-1:0];

    AST_QUIET_IN_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        !replay_i |=> !out_valid_o); // R2

    AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        q.fill[wr_slot_i] <= FULL_V); // R7

    AST_FULL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && q.fill[wr_slot_i] == FULL_V) |=> q.ovf[$past(wr_slot_i)]); // R7

    AST_SWITCH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.fill[$past(clr_slot_i)] == '0)); // R9

    AST_SWITCH_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !out_valid_o); // R9

    AST_RELEASE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_i && !clr_i && !push_i && q.fill[rd_slot_i] == '0) |=> !out_valid_o); // R3

endmodule

// File: rtl/memo_prefetch_top.sv
module memo_prefetch_top
    import memo_pf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DEPTH_LOG2 = 3,
    parameter int NSLOT      = 2,
    parameter int LEAD       = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_replay_i,
    input  logic [CNT_W-1:0]  icount_i,
    input  logic              rec_valid_i,
    input  logic [1:0]        rec_kind_i,
    input  logic [ADDR_W-1:0] rec_addr_i,
    input  logic [ADDR_W-1:0] rec_target_i,
    input  logic              rec_taken_i,
    input  logic              task_switch_i,
    output logic              ipf_valid_o,
    output logic [ADDR_W-1:0] ipf_addr_o,
    output logic              dpf_valid_o,
    output logic [ADDR_W-1:0] dpf_addr_o,
    output logic              bp_valid_o,
    output logic [ADDR_W-1:0] bp_addr_o,
    output logic [ADDR_W-1:0] bp_target_o,
    output logic              bp_taken_o,
    output logic [NSLOT-1:0]  ovf_o
);

    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int BR_W   = 2 * ADDR_W + 1;

    logic [SLOT_W-1:0] wr_slot, rd_slot, clr_slot;
    logic              clr;
    logic              rec_ok;
    logic              push_i_l, push_d_l, push_b_l;
    logic [NSLOT-1:0]  ovf_i_l, ovf_d_l, ovf_b_l;
    logic [BR_W-1:0]   br_pay_in, br_pay_out;

    assign rec_ok    = rec_valid_i && !mode_replay_i;
    assign push_i_l  = rec_ok && (rec_kind_i == KIND_INSN);
    assign push_d_l  = rec_ok && (rec_kind_i == KIND_DATA);
    assign push_b_l  = rec_ok && (rec_kind_i == KIND_BRANCH);
    assign br_pay_in = {rec_taken_i, rec_target_i, rec_addr_i};

    memo_pf_slots #(.NSLOT(NSLOT)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .switch_i   (task_switch_i),
        .replay_i   (mode_replay_i),
        .wr_slot_o  (wr_slot),
        .rd_slot_o  (rd_slot),
        .clr_o      (clr),
        .clr_slot_o (clr_slot)
    );

    memo_pf_list #(.PAY_W(ADDR_W), .CNT_W(CNT_W), .DEPTH_LOG2(DEPTH_LOG2),
                   .NSLOT(NSLOT), .LEAD(LEAD)) u_ilist (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i_l), .wr_slot_i(wr_slot), .push_cnt_i(icount_i), .push_pay_i(rec_addr_i),
        .replay_i(mode_replay_i), .rd_slot_i(rd_slot), .live_cnt_i(icount_i),
        .clr_i(clr), .clr_slot_i(clr_slot),
        .out_valid_o(ipf_valid_o), .out_pay_o(ipf_addr_o), .ovf_o(ovf_i_l)
    );

    memo_pf_list #(.PAY_W(ADDR_W), .CNT_W(CNT_W), .DEPTH_LOG2(DEPTH_LOG2),
                   .NSLOT(NSLOT), .LEAD(LEAD)) u_dlist (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_d_l), .wr_slot_i(wr_slot), .push_cnt_i(icount_i), .push_pay_i(rec_addr_i),
        .replay_i(mode_replay_i), .rd_slot_i(rd_slot), .live_cnt_i(icount_i),
        .clr_i(clr), .clr_slot_i(clr_slot),
        .out_valid_o(dpf_valid_o), .out_pay_o(dpf_addr_o), .ovf_o(ovf_d_l)
    );

    memo_pf_list #(.PAY_W(BR_W), .CNT_W(CNT_W), .DEPTH_LOG2(DEPTH_LOG2),
                   .NSLOT(NSLOT), .LEAD(LEAD)) u_blist (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_b_l), .wr_slot_i(wr_slot), .push_cnt_i(icount_i), .push_pay_i(br_pay_in),
        .replay_i(mode_replay_i), .rd_slot_i(rd_slot), .live_cnt_i(icount_i),
        .clr_i(clr), .clr_slot_i(clr_slot),
        .out_valid_o(bp_valid_o), .out_pay_o(br_pay_out), .ovf_o(ovf_b_l)
    );

    assign bp_addr_o   = br_pay_out[ADDR_W-1:0];
    assign bp_target_o = br_pay_out[2*ADDR_W-1:ADDR_W];
    assign bp_taken_o  = br_pay_out[2*ADDR_W];
    assign ovf_o       = ovf_i_l | ovf_d_l | ovf_b_l;

    AST_IGNORE_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_replay_i && !task_switch_i) |=> $stable(ovf_o)); // R10

endmodule

// File: tb/memo_prefetch_top_test.sv
`timescale 1ns/1ps
module memo_prefetch_top_test;

    localparam int NSLOT = 2;
    localparam int DEPTH = 8;
    localparam int LEAD  = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] icount = '0;
    logic        rv = 1'b0;
    logic [1:0]  kind = 2'd3;
    logic [31:0] addr = '0, target = '0;
    logic        taken = 1'b0;
    logic        sw = 1'b0;

    logic        ipf_v, dpf_v, bp_v, bp_tk;
    logic [31:0] ipf_a, dpf_a, bp_a, bp_t;
    logic [NSLOT-1:0] ovf;

    memo_prefetch_top uut (
        .clk(clk), .rst_n(rst_n), .mode_replay_i(mode), .icount_i(icount),
        .rec_valid_i(rv), .rec_kind_i(kind), .rec_addr_i(addr), .rec_target_i(target),
        .rec_taken_i(taken), .task_switch_i(sw),
        .ipf_valid_o(ipf_v), .ipf_addr_o(ipf_a), .dpf_valid_o(dpf_v), .dpf_addr_o(dpf_a),
        .bp_valid_o(bp_v), .bp_addr_o(bp_a), .bp_target_o(bp_t), .bp_taken_o(bp_tk),
        .ovf_o(ovf)
    );

    always #4 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    string tag = "R1";

    // reference model
    int unsigned m_cnt [3][NSLOT][$];
    logic [64:0] m_pay [3][NSLOT][$];
    int          m_wr = 0, m_rd = 0;
    logic [NSLOT-1:0] e_ovf = '0;
    logic [2:0]  e_v = '0;
    logic [64:0] e_pay [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < 3; l++)
                for (int s = 0; s < NSLOT; s++) begin
                    m_cnt[l][s].delete();
                    m_pay[l][s].delete();
                end
            m_wr = 0; m_rd = 0; e_ovf = '0; e_v = '0;
        end else begin
            e_v = '0;
            if (mode && sw) begin
                for (int l = 0; l < 3; l++) begin
                    m_cnt[l][m_rd].delete();
                    m_pay[l][m_rd].delete();
                end
                e_ovf[m_rd] = 1'b0;
                m_rd = (m_rd + 1) % NSLOT;
            end else if (mode) begin
                for (int l = 0; l < 3; l++)
                    if (m_cnt[l][m_rd].size() > 0 &&
                        (int'(icount) + LEAD) > int'(m_cnt[l][m_rd][0])) begin
                        void'(m_cnt[l][m_rd].pop_front());
                        e_pay[l] = m_pay[l][m_rd].pop_front();
                        e_v[l] = 1'b1;
                    end
            end
            if (!mode && rv && kind != 2'd3) begin
                if (m_cnt[kind][m_wr].size() < DEPTH) begin
                    m_cnt[kind][m_wr].push_back(int'(icount));
                    m_pay[kind][m_wr].push_back((kind == 2'd2) ? {taken, target, addr}
                                                               : {33'd0, addr});
                end else begin
                    e_ovf[m_wr] = 1'b1;
                end
            end
            if (!mode && sw) m_wr = (m_wr + 1) % NSLOT;
        end
    end

    task automatic chk(input string what, input logic [64:0] act, input logic [64:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("ipf_valid", {64'd0, ipf_v}, {64'd0, e_v[0]});
        if (e_v[0]) chk("ipf_addr", {33'd0, ipf_a}, e_pay[0]);
        chk("dpf_valid", {64'd0, dpf_v}, {64'd0, e_v[1]});
        if (e_v[1]) chk("dpf_addr", {33'd0, dpf_a}, e_pay[1]);
        chk("bp_valid", {64'd0, bp_v}, {64'd0, e_v[2]});
        if (e_v[2]) chk("bp_fields (R6)", {bp_tk, bp_t, bp_a}, e_pay[2]);
        chk("ovf", {63'd0, ovf}, {63'd0, e_ovf});
    end

    task automatic step(input logic r, input logic [1:0] k, input logic [31:0] a,
                        input logic [31:0] t, input logic tk, input logic s,
                        input int ic);
        @(negedge clk);
        rv = r; kind = k; addr = a; target = t; taken = tk; sw = s; icount = 16'(ic);
    endtask

    task automatic rec(input logic [1:0] k, input logic [31:0] a, input int ic);
        step(1'b1, k, a, a ^ 32'h00F0_0000, a[4], 1'b0, ic);
    endtask

    task automatic hold(input int ic, input int n);
        for (int i = 0; i < n; i++) step(mode, 2'd0, 32'hDEAD_0000 + 32'(i), 32'h0, 1'b0, 1'b0, ic);
    endtask

    task automatic ramp(input int from, input int to, input int stp);
        for (int c = from; c <= to; c += stp)
            step(1'b1, 2'd1, 32'hBAD0_0000 + 32'(c), 32'h0, 1'b1, 1'b0, c);
    endtask

    task automatic pulse(input int ic);
        step(1'b0, 2'd3, 32'h0, 32'h0, 1'b0, 1'b1, ic);
    endtask

    logic done = 1'b0;

    initial begin
        #(8 * 200000);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hold(0, 2);

        // slot 0 recording
        tag = "R2";
        mode = 1'b0;
        rec(2'd0, 32'h1000_0010, 10);
        rec(2'd1, 32'h2000_0120, 120);
        rec(2'd1, 32'h2000_0125, 125);
        rec(2'd3, 32'hFFFF_FFFF, 130);
        rec(2'd0, 32'h1000_0150, 150);
        rec(2'd2, 32'h3000_0200, 200);
        rec(2'd0, 32'h1000_0300, 300);
        tag = "R8";
        step(1'b1, 2'd2, 32'h3000_0400, 32'h3100_0400, 1'b0, 1'b1, 400);

        // slot 1 recording, overflow of instruction list
        tag = "R7";
        for (int i = 0; i < DEPTH + 2; i++) rec(2'd0, 32'h1100_0000 + 32'(i), 100 + 50 * i);
        rec(2'd1, 32'h2100_0050, 50);
        rec(2'd2, 32'h3100_0700, 700);
        pulse(0);
        hold(0, 2);

        // replay slot 0
        mode = 1'b1;
        tag = "R5";
        hold(0, 4);
        tag = "R4";
        hold(30, 4);
        tag = "R3";
        ramp(31, 101, 5);
        hold(101, 3);
        tag = "R10";
        ramp(102, 250, 4);
        tag = "R9";
        pulse(250);
        hold(0, 3);

        // replay slot 1 with the entries kept after overflow
        tag = "R7";
        ramp(0, 800, 10);
        hold(800, 4);
        tag = "R9";
        pulse(800);
        tag = "R6";
        hold(1000, 4);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule